// File: doc/BRIEF.md
# Pattern-Gated Output Trigger Unit

This block is a single output gating stage of an event routing fabric. It merges trigger pulses from four edge-trigger channels with an optional internal peripheral trigger, chosen from three candidates. The result is one trigger output. In parallel, it checks a pattern over a programmable subset of four channel status flags. The registered outcome of that check is presented as the pattern result.

A gating policy decides how the pattern qualifies the interrupt output. The four policies are never, always, on match and on miss. The gating output shows the current qualification level. When the pattern-change event is enabled, any change of the pattern result also fires a one-cycle trigger.

Configuration is one word, written through a write strobe. Every output is registered and appears one clock after the inputs that cause it.

Top module: `trig_gate_unit`

## Requirements
- R1: While and right after a synchronous active-high reset, all outputs are 0 and every configuration field is 0.
- R2: Source select field cfg_wdata[1:0] picks the internal trigger: 00 disables it, and 01, 10 and 11 select periph_trig_i[0], [1] and [2] respectively.
- R3: trig_o is 1 in the cycle after any channel pulse or the selected internal trigger is 1, and is 0 otherwise (absent a pattern-change event).
- R4: pattern_o is the registered pattern check: it is 1 when every flag whose include bit cfg_wdata[4+k] is set for channel k is 1, and it is 1 when no flag is included.
- R5: Gating mode cfg_wdata[3:2]=00 keeps gate_o at 0, and irq_o never becomes 1.
- R6: Gating mode 01 keeps gate_o at 1, and irq_o is 1 exactly when trig_o is 1.
- R7: Gating mode 10 makes gate_o equal pattern_o, and irq_o is 1 only for a trigger while the pattern matches.
- R8: Gating mode 11 makes gate_o the inverse of pattern_o, and irq_o is 1 only for a trigger while the pattern misses.
- R9: With event enable cfg_wdata[8]=1, a change of the pattern result yields a trig_o pulse lasting exactly one cycle. With the enable at 0, a pattern change yields no trigger.
- R10: The configuration is loaded only in a cycle with cfg_we=1. cfg_wdata has no effect when cfg_we is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 9 | Configuration word: source select, gating mode, include mask, event enable |
| chan_pulse_i | input | 4 | Trigger pulses from the four channels addressed to this unit |
| periph_trig_i | input | 3 | Internal peripheral trigger candidates 1 to 3 |
| chan_flag_i | input | 4 | Channel status flags |
| trig_o | output | 1 | Registered trigger output |
| gate_o | output | 1 | Registered gating level |
| irq_o | output | 1 | Registered gated interrupt pulse |
| pattern_o | output | 1 | Registered pattern result, 1 for match |

## Verification
Suppose the registered pattern value or the configuration word is corrupted. That fault shows up one clock later as a gate_o that disagrees with pattern_o under the selected policy, or as an irq_o that does not track trig_o. A stale pattern register is the other risk. It shows up either as a spurious one-cycle trig_o when the event enable is set, or as a pattern_o lagging by more than one cycle. The bench therefore samples every output exactly one cycle after its cause. It also checks that the event pulse ends after a single cycle.

// File: rtl/og_pkg.sv
package og_pkg;
  localparam int NUM_CH     = 4;
  localparam int NUM_PERIPH = 3;

  typedef enum logic [1:0] {
    GATE_NEVER  = 2'b00,
    GATE_ALWAYS = 2'b01,
    GATE_MATCH  = 2'b10,
    GATE_MISS   = 2'b11
  } gate_mode_e;
endpackage

// File: rtl/og_cfg_reg.sv
module og_cfg_reg #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cfg_q
);
  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= '0;
    else if (we) cfg_q <= wdata;
  end
endmodule

// File: rtl/og_pattern.sv
module og_pattern #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] flags,
  input  logic [NCH-1:0] incl,
  input  logic           evt_en,
  output logic           match_now,
  output logic           pattern_q,
  output logic           change_evt
);
  // excluded flags count as satisfied, so an empty mask always matches
  assign match_now  = &(flags | ~incl);
  assign change_evt = evt_en & (match_now ^ pattern_q);

  always_ff @(posedge clk) begin
    if (rst) pattern_q <= 1'b0;
    else     pattern_q <= match_now;
  end
endmodule

// File: rtl/og_trig_src.sv
module og_trig_src #(
  parameter int NCH   = 4,
  parameter int NPER  = 3,
  parameter int SEL_W = 2
) (
  input  logic [NCH-1:0]   pulses,
  input  logic [NPER-1:0]  periph,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             change_evt,
  output logic             trig_now
);
  logic [NPER-1:0] hit;

  generate
    for (genvar i = 0; i < NPER; i++) begin : g_src
      // code value 0 disables; code i+1 picks candidate i
      assign hit[i] = periph[i] & (src_sel == SEL_W'(i + 1));
    end
  endgenerate

  assign trig_now = (|pulses) | (|hit) | change_evt;
endmodule

// File: rtl/og_gate.sv
module og_gate
  import og_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  gate_mode_e mode,
  input  logic       match_now,
  input  logic       trig_now,
  output logic       trig_o,
  output logic       gate_o,
  output logic       irq_o
);
  logic gate_now;

  always_comb begin
    unique case (mode)
      GATE_NEVER:  gate_now = 1'b0;
      GATE_ALWAYS: gate_now = 1'b1;
      GATE_MATCH:  gate_now = match_now;
      GATE_MISS:   gate_now = ~match_now;
      default:     gate_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_o <= 1'b0;
      gate_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      trig_o <= trig_now;
      gate_o <= gate_now;
      irq_o  <= trig_now & gate_now;
    end
  end
endmodule

// File: rtl/trig_gate_unit.sv
module trig_gate_unit
  import og_pkg::*;
#(
  parameter int NCH  = og_pkg::NUM_CH,
  parameter int NPER = og_pkg::NUM_PERIPH,
  localparam int SEL_W = $clog2(NPER + 1),
  localparam int CFG_W = SEL_W + 2 + NCH + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [NCH-1:0]   chan_pulse_i,
  input  logic [NPER-1:0]  periph_trig_i,
  input  logic [NCH-1:0]   chan_flag_i,
  output logic             trig_o,
  output logic             gate_o,
  output logic             irq_o,
  output logic             pattern_o
);
  localparam int MODE_LO = SEL_W;
  localparam int INCL_LO = SEL_W + 2;
  localparam int EVT_BIT = CFG_W - 1;

  logic [CFG_W-1:0] cfg_q;
  logic [SEL_W-1:0] src_sel;
  gate_mode_e       mode;
  logic [NCH-1:0]   incl;
  logic             evt_en;
  logic             match_now, change_evt, trig_now;

  og_cfg_reg #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .cfg_q(cfg_q)
  );

  assign src_sel = cfg_q[SEL_W-1:0];
  assign mode    = gate_mode_e'(cfg_q[MODE_LO+1:MODE_LO]);
  assign incl    = cfg_q[INCL_LO+NCH-1:INCL_LO];
  assign evt_en  = cfg_q[EVT_BIT];

  og_pattern #(.NCH(NCH)) u_pat (
    .clk(clk), .rst(rst), .flags(chan_flag_i), .incl(incl), .evt_en(evt_en),
    .match_now(match_now), .pattern_q(pattern_o), .change_evt(change_evt)
  );

  og_trig_src #(.NCH(NCH), .NPER(NPER), .SEL_W(SEL_W)) u_src (
    .pulses(chan_pulse_i), .periph(periph_trig_i), .src_sel(src_sel),
    .change_evt(change_evt), .trig_now(trig_now)
  );

  og_gate u_gate (
    .clk(clk), .rst(rst), .mode(mode), .match_now(match_now),
    .trig_now(trig_now), .trig_o(trig_o), .gate_o(gate_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/trig_gate_unit_chk.sv
module trig_gate_unit_chk #(
  parameter int NCH   = 4,
  parameter int NPER  = 3,
  parameter int SEL_W = 2,
  parameter int CFG_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_q,
  input logic [NCH-1:0]   chan_pulse_i,
  input logic             trig_o,
  input logic             gate_o,
  input logic             irq_o,
  input logic             pattern_o
);
  logic [1:0]     mode;
  logic [NCH-1:0] incl;
  assign mode = cfg_q[SEL_W+1:SEL_W];
  assign incl = cfg_q[SEL_W+2+NCH-1:SEL_W+2];

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!trig_o && !gate_o && !irq_o && !pattern_o && cfg_q == '0));
  assert_no_src_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (chan_pulse_i == '0 && cfg_q[SEL_W-1:0] == '0 && !cfg_q[CFG_W-1]) |=> !trig_o);
  assert_empty_mask_match_R4: assert property (@(posedge clk) disable iff (rst)
    (incl == '0) |=> pattern_o);
  assert_never_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (!gate_o && !irq_o));
  assert_always_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |=> (gate_o && irq_o == trig_o));
  assert_match_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |=> (gate_o == pattern_o));
  assert_miss_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> (gate_o != pattern_o));
  assert_irq_needs_trig_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> trig_o);
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(cfg_q));
endmodule

bind trig_gate_unit trig_gate_unit_chk #(
  .NCH(NCH), .NPER(NPER), .SEL_W(SEL_W), .CFG_W(CFG_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_q(cfg_q),
  .chan_pulse_i(chan_pulse_i), .trig_o(trig_o), .gate_o(gate_o),
  .irq_o(irq_o), .pattern_o(pattern_o)
);

// File: tb/trig_gate_unit_tb.sv
module trig_gate_unit_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_we;
  logic [8:0] cfg_wdata;
  logic [3:0] chan_pulse_i;
  logic [2:0] periph_trig_i;
  logic [3:0] chan_flag_i;
  logic       trig_o, gate_o, irq_o, pattern_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  trig_gate_unit u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .chan_pulse_i(chan_pulse_i), .periph_trig_i(periph_trig_i),
    .chan_flag_i(chan_flag_i), .trig_o(trig_o), .gate_o(gate_o),
    .irq_o(irq_o), .pattern_o(pattern_o)
  );

  typedef struct packed {
    logic [8:0] cfg;
    logic [3:0] pls;
    logic [2:0] per;
    logic [3:0] flg;
    logic       et, eg, ei, ep;
  } vec_t;

  // cfg: [8] event enable, [7:4] include mask, [3:2] gating mode, [1:0] source
  localparam vec_t VEC [14] = '{
    '{9'h000, 4'b0001, 3'b000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b1}, // R5 R3
    '{9'h004, 4'b0000, 3'b111, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b1}, // R2 src off
    '{9'h005, 4'b0000, 3'b001, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b1}, // R2 input 1
    '{9'h006, 4'b0000, 3'b001, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b1}, // R2 wrong input
    '{9'h006, 4'b0000, 3'b010, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b1}, // R2 input 2
    '{9'h007, 4'b0000, 3'b100, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b1}, // R2 input 3
    '{9'h007, 4'b0000, 3'b011, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b1}, // R2 R6
    '{9'h038, 4'b0100, 3'b000, 4'b0011, 1'b1, 1'b1, 1'b1, 1'b1}, // R7 R4 match
    '{9'h038, 4'b0100, 3'b000, 4'b1101, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 R4 miss
    '{9'h0FC, 4'b1000, 3'b000, 4'b0111, 1'b1, 1'b1, 1'b1, 1'b0}, // R8 miss
    '{9'h0FC, 4'b1000, 3'b000, 4'b1111, 1'b1, 1'b0, 1'b0, 1'b1}, // R8 match
    '{9'h0FC, 4'b0000, 3'b000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 no trigger
    '{9'h088, 4'b0010, 3'b000, 4'b1000, 1'b1, 1'b1, 1'b1, 1'b1}, // R7 single flag
    '{9'h000, 4'b1111, 3'b111, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b1}  // R5 all active
  };

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [8:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R5";
      2'b01:   return "R6";
      2'b10:   return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0;
    chan_pulse_i = '0; periph_trig_i = '0; chan_flag_i = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset even with inputs active
    chan_pulse_i = 4'hF; chan_flag_i = 4'hF;
    @(negedge clk);
    check("R1 trig", trig_o, 1'b0);
    check("R1 gate", gate_o, 1'b0);
    check("R1 irq", irq_o, 1'b0);
    check("R1 pattern", pattern_o, 1'b0);
    chan_pulse_i = '0; chan_flag_i = '0;
    rst = 1'b0;
    @(negedge clk);
    check("R1 trig after reset", trig_o, 1'b0);
    check("R1 gate after reset (mode 00)", gate_o, 1'b0);

    // vector table
    foreach (VEC[i]) begin
      write_cfg(VEC[i].cfg);
      chan_flag_i = VEC[i].flg;
      @(negedge clk);
      chan_pulse_i = VEC[i].pls; periph_trig_i = VEC[i].per;
      @(negedge clk);
      check($sformatf("R3 trig vec %0d", i), trig_o, VEC[i].et);
      check($sformatf("%s gate vec %0d", mode_tag(VEC[i].cfg[3:2]), i), gate_o, VEC[i].eg);
      check($sformatf("%s irq vec %0d", mode_tag(VEC[i].cfg[3:2]), i), irq_o, VEC[i].ei);
      check($sformatf("R4 pattern vec %0d", i), pattern_o, VEC[i].ep);
      chan_pulse_i = '0; periph_trig_i = '0;
    end

    // R4: pattern latency of one cycle
    write_cfg(9'h014);            // include channel 0, mode 01
    chan_flag_i = 4'b0000;
    @(negedge clk);
    check("R4 pattern miss", pattern_o, 1'b0);
    chan_flag_i = 4'b0001;
    @(negedge clk);
    check("R4 pattern follows in one cycle", pattern_o, 1'b1);
    check("R9 no event pulse when disabled", trig_o, 1'b0);

    // R9: event enabled, pattern change gives exactly one trigger cycle
    chan_flag_i = 4'b0000;
    @(negedge clk);
    write_cfg(9'h114);
    @(negedge clk);
    check("R9 no pulse while stable", trig_o, 1'b0);
    chan_flag_i = 4'b0001;
    @(negedge clk);
    check("R9 pulse on change", trig_o, 1'b1);
    check("R9 irq on change (mode 01)", irq_o, 1'b1);
    @(negedge clk);
    check("R9 pulse lasts one cycle", trig_o, 1'b0);
    chan_flag_i = 4'b0000;
    @(negedge clk);
    check("R9 pulse on falling change", trig_o, 1'b1);
    @(negedge clk);
    check("R9 falling pulse ends", trig_o, 1'b0);

    // R10: data without write strobe is ignored
    write_cfg(9'h004);            // mode 01, no event, no mask
    cfg_wdata = 9'h000;           // would select mode 00 if loaded
    @(negedge clk);
    chan_pulse_i = 4'b0001;
    @(negedge clk);
    check("R10 gate kept at mode 01", gate_o, 1'b1);
    check("R10 irq kept at mode 01", irq_o, 1'b1);
    chan_pulse_i = '0;
    cfg_wdata = 9'h001;           // would enable source 1 if loaded
    periph_trig_i = 3'b001;
    @(negedge clk);
    check("R10 source select not loaded", trig_o, 1'b0);
    periph_trig_i = '0;
    @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule